// File: doc/BRIEF.md
# FIFO-Level Xon/Xoff Transmit Generator

This block watches how full a receive FIFO is and, from that, decides when the remote sender must be told to pause or to resume. When the count climbs to an upper threshold, it asks the local transmitter to insert the pause character or characters. When the count later drains to a lower threshold, it asks for the resume character or characters. The pair of thresholds comes from a fixed lookup. That lookup is indexed by a 2-bit trigger select and by a depth mode, which is either 16 or 64 entries.

Requests go to the transmitter through a valid/ready handshake, one character per accept. The transmitter gives them priority over FIFO data and accepts them only between frames. A two-character message is always sent whole. A state bit records whether the remote side has been stopped. Because of this bit, each message goes out once per threshold crossing and never repeats. The block also raises a receive-level flag at the same count as the pause threshold.

Top module: `flow_xmit_gen`

## Requirements
- R1: After reset, `ins_valid_o` = 0 and `remote_stopped_o` = 0.
- R2: With `deep_mode_i` = 0, trigger select values 0, 1, 2 and 3 give pause thresholds of 1, 4, 8 and 14, and resume thresholds of 0, 1, 4 and 8.
- R3: With `deep_mode_i` = 1, trigger select values 0, 1, 2 and 3 give pause thresholds of 8, 16, 56 and 60, and resume thresholds of 0, 8, 16 and 56.
- R4: `rx_level_o` is 1 exactly when `fifo_cnt_i` is greater than or equal to the pause threshold.
- R5: While the remote side is running and `fifo_cnt_i` is at or above the pause threshold, the request becomes valid on the next cycle, carrying `xoff1_i`. In double mode (`dual_char_i` = 1), `xoff2_i` follows once the first character is accepted. `remote_stopped_o` rises in the cycle after the last pause character is accepted.
- R6: In single mode (`dual_char_i` = 0), only `xoff1_i` is sent for a pause and only `xon1_i` for a resume.
- R7: While the remote side is stopped and `fifo_cnt_i` is at or below the resume threshold, the block requests `xon1_i` and then, in double mode, `xon2_i`. `remote_stopped_o` falls in the cycle after the last resume character is accepted.
- R8: No pause message is requested while the remote side is stopped, and no resume message while it is running. A count that stays past a threshold therefore produces no repeat.
- R9: A pending request keeps `ins_valid_o` high and `ins_char_o` unchanged until `ins_ready_i` accepts it. A started sequence completes whatever `fifo_cnt_i` does in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_cnt_i | input | CNT_W | Receive FIFO occupancy |
| trig_sel_i | input | 2 | Trigger level select |
| deep_mode_i | input | 1 | 0: 16-entry thresholds, 1: 64-entry thresholds |
| dual_char_i | input | 1 | 1: two-character messages, 0: one character |
| xon1_i | input | CHAR_W | First resume character |
| xon2_i | input | CHAR_W | Second resume character |
| xoff1_i | input | CHAR_W | First pause character |
| xoff2_i | input | CHAR_W | Second pause character |
| ins_ready_i | input | 1 | Transmitter accepts the offered character |
| ins_valid_o | output | 1 | Insert request pending |
| ins_char_o | output | CHAR_W | Character to insert |
| remote_stopped_o | output | 1 | Pause message has been sent and no resume yet |
| rx_level_o | output | 1 | Receive count at or above the pause threshold |

## Verification
The bench builds the block with its defaults: CNT_W = 7, so counts reach 64, and CHAR_W = 8. This lets every entry of both threshold tables be reached, including the 60/56 pair that only the deep mode uses. It walks each trigger select in both modes, checking one count below and at each threshold. Random counts, ready stalls and changes of mode then exercise back-to-back crossings, sequences interrupted by count swings, and single versus double messages.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [2:0] {
    PH_RUN  = 3'd0,
    PH_OFF1 = 3'd1,
    PH_OFF2 = 3'd2,
    PH_STOP = 3'd3,
    PH_ON1  = 3'd4,
    PH_ON2  = 3'd5
  } fc_phase_e;

  typedef enum logic [1:0] {
    CH_XOFF1 = 2'd0,
    CH_XOFF2 = 2'd1,
    CH_XON1  = 2'd2,
    CH_XON2  = 2'd3
  } fc_char_e;
endpackage

// File: rtl/fc_thr_lut.sv
module fc_thr_lut #(
  parameter int CNT_W = 7
) (
  input  logic [1:0]       sel_i,
  input  logic             deep_i,
  output logic [CNT_W-1:0] off_thr_o,
  output logic [CNT_W-1:0] on_thr_o
);
  int unsigned off_v, on_v;

  always_comb begin
    unique case ({deep_i, sel_i})
      3'b000: begin off_v = 1;  on_v = 0;  end
      3'b001: begin off_v = 4;  on_v = 1;  end
      3'b010: begin off_v = 8;  on_v = 4;  end
      3'b011: begin off_v = 14; on_v = 8;  end
      3'b100: begin off_v = 8;  on_v = 0;  end
      3'b101: begin off_v = 16; on_v = 8;  end
      3'b110: begin off_v = 56; on_v = 16; end
      default: begin off_v = 60; on_v = 56; end
    endcase
    off_thr_o = CNT_W'(off_v);
    on_thr_o  = CNT_W'(on_v);
  end

  // the table must always leave a hysteresis gap
  always_comb begin
    a_r2_r3_gap: assert (off_v > on_v);
  end
endmodule

// File: rtl/fc_seq.sv
module fc_seq
  import fc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hit_off_i,
  input  logic     hit_on_i,
  input  logic     dual_i,
  input  logic     ready_i,
  output logic     valid_o,
  output fc_char_e char_sel_o,
  output logic     stopped_o
);
  fc_phase_e ph_q, ph_d;
  logic      acc;

  assign acc = valid_o && ready_i;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_RUN:  if (hit_off_i) ph_d = PH_OFF1;
      PH_OFF1: if (acc) ph_d = dual_i ? PH_OFF2 : PH_STOP;
      PH_OFF2: if (acc) ph_d = PH_STOP;
      PH_STOP: if (hit_on_i) ph_d = PH_ON1;
      PH_ON1:  if (acc) ph_d = dual_i ? PH_ON2 : PH_RUN;
      PH_ON2:  if (acc) ph_d = PH_RUN;
      default: ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ph_q <= PH_RUN;
    else         ph_q <= ph_d;

  always_comb begin
    valid_o    = 1'b0;
    char_sel_o = CH_XOFF1;
    unique case (ph_q)
      PH_OFF1: begin valid_o = 1'b1; char_sel_o = CH_XOFF1; end
      PH_OFF2: begin valid_o = 1'b1; char_sel_o = CH_XOFF2; end
      PH_ON1:  begin valid_o = 1'b1; char_sel_o = CH_XON1;  end
      PH_ON2:  begin valid_o = 1'b1; char_sel_o = CH_XON2;  end
      default: ;
    endcase
  end

  assign stopped_o = (ph_q == PH_STOP) || (ph_q == PH_ON1) || (ph_q == PH_ON2);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(char_sel_o));
  a_r5_stop_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped_o) |-> $past(acc));
  a_r7_run_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stopped_o) |-> $past(acc));
endmodule

// File: rtl/flow_xmit_gen.sv
module flow_xmit_gen
  import fc_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  fifo_cnt_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              deep_mode_i,
  input  logic              dual_char_i,
  input  logic [CHAR_W-1:0] xon1_i,
  input  logic [CHAR_W-1:0] xon2_i,
  input  logic [CHAR_W-1:0] xoff1_i,
  input  logic [CHAR_W-1:0] xoff2_i,
  input  logic              ins_ready_i,
  output logic              ins_valid_o,
  output logic [CHAR_W-1:0] ins_char_o,
  output logic              remote_stopped_o,
  output logic              rx_level_o
);
  logic [CNT_W-1:0] off_thr, on_thr;
  logic             hit_off, hit_on;
  fc_char_e         char_sel;

  fc_thr_lut #(.CNT_W(CNT_W)) u_lut (
    .sel_i     (trig_sel_i),
    .deep_i    (deep_mode_i),
    .off_thr_o (off_thr),
    .on_thr_o  (on_thr)
  );

  assign hit_off    = fifo_cnt_i >= off_thr;
  assign hit_on     = fifo_cnt_i <= on_thr;
  assign rx_level_o = hit_off;

  fc_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_off_i  (hit_off),
    .hit_on_i   (hit_on),
    .dual_i     (dual_char_i),
    .ready_i    (ins_ready_i),
    .valid_o    (ins_valid_o),
    .char_sel_o (char_sel),
    .stopped_o  (remote_stopped_o)
  );

  always_comb begin
    unique case (char_sel)
      CH_XOFF1: ins_char_o = xoff1_i;
      CH_XOFF2: ins_char_o = xoff2_i;
      CH_XON1:  ins_char_o = xon1_i;
      default:  ins_char_o = xon2_i;
    endcase
  end

  a_r8_only_xon_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remote_stopped_o && ins_valid_o |-> (ins_char_o == xon1_i) || (ins_char_o == xon2_i));
  a_r5_request_after_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !remote_stopped_o && !ins_valid_o && rx_level_o |=> ins_valid_o);
  a_r4_level_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level_o |-> fifo_cnt_i != '0);
endmodule

// File: tb/flow_xmit_gen_tb_top.sv
module flow_xmit_gen_tb_top;
  localparam int CNT_W  = 7;
  localparam int CHAR_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [CNT_W-1:0]  fifo_cnt_i = '0;
  logic [1:0]        trig_sel_i = '0;
  logic              deep_mode_i = 1'b0;
  logic              dual_char_i = 1'b1;
  logic [CHAR_W-1:0] xon1_i = 8'h11, xon2_i = 8'h12, xoff1_i = 8'h13, xoff2_i = 8'h14;
  logic              ins_ready_i = 1'b0;
  logic              ins_valid_o, remote_stopped_o, rx_level_o;
  logic [CHAR_W-1:0] ins_char_o;

  always #2 clk_i = ~clk_i;

  flow_xmit_gen #(.CNT_W(CNT_W), .CHAR_W(CHAR_W)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  int ph = 0; // 0 run,1 off1,2 off2,3 stop,4 on1,5 on2

  function automatic int off_thr(bit deep, int sel);
    int t16[4] = '{1, 4, 8, 14};
    int t64[4] = '{8, 16, 56, 60};
    return deep ? t64[sel] : t16[sel];
  endfunction
  function automatic int on_thr(bit deep, int sel);
    int t16[4] = '{0, 1, 4, 8};
    int t64[4] = '{0, 8, 16, 56};
    return deep ? t64[sel] : t16[sel];
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // at negedge: check outputs vs model, then drive inputs and advance model
  task automatic step(int cnt, bit rdy);
    bit ev = (ph == 1 || ph == 2 || ph == 4 || ph == 5);
    int ec = (ph == 1) ? xoff1_i : (ph == 2) ? xoff2_i : (ph == 4) ? xon1_i : xon2_i;
    bit acc;
    chk("R5_R7_R8 valid", ins_valid_o, ev);
    if (ev) chk("R5_R6_R7_R9 char", ins_char_o, ec);
    chk("R5_R7 stopped", remote_stopped_o, ph >= 3);
    fifo_cnt_i  = CNT_W'(cnt);
    ins_ready_i = rdy;
    #0;
    chk("R4 level", rx_level_o, cnt >= off_thr(deep_mode_i, trig_sel_i));
    acc = ev && rdy;
    case (ph)
      0: if (cnt >= off_thr(deep_mode_i, trig_sel_i)) ph = 1;
      1: if (acc) ph = dual_char_i ? 2 : 3;
      2: if (acc) ph = 3;
      3: if (cnt <= on_thr(deep_mode_i, trig_sel_i)) ph = 4;
      4: if (acc) ph = dual_char_i ? 5 : 0;
      5: if (acc) ph = 0;
      default: ph = 0;
    endcase
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    fifo_cnt_i = '0;
    ins_ready_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    ph = 0;
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int unused = $urandom(32'h5eed);
    do_reset();
    chk("R1 valid", ins_valid_o, 0);
    chk("R1 stopped", remote_stopped_o, 0);

    // R2/R3 threshold sweep
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 4; s++) begin
        int ot, nt;
        deep_mode_i = d[0];
        trig_sel_i  = 2'(s);
        dual_char_i = 1'b1;
        do_reset();
        ot = off_thr(d[0], s);
        nt = on_thr(d[0], s);
        step(ot - 1, 0);
        step(ot - 1, 0);
        chk(d ? "R3 no xoff below" : "R2 no xoff below", ins_valid_o, 0);
        step(ot, 0);
        chk(d ? "R3 xoff at thr" : "R2 xoff at thr", ins_valid_o, 1);
        step(ot + 1, 1);
        step(nt + 1, 1);
        step(nt + 1, 0);
        chk("R8 no xon above", ins_valid_o, 0);
        step(nt + 1, 0);
        chk(d ? "R3 no xon above" : "R2 no xon above", ins_valid_o, 0);
        step(nt, 0);
        chk(d ? "R3 xon at thr" : "R2 xon at thr", ins_valid_o, 1);
        step(nt, 1);
        step(nt, 1);
        step(nt, 0);
      end
    end

    // R6 single mode directed
    deep_mode_i = 0; trig_sel_i = 2; dual_char_i = 0;
    do_reset();
    step(10, 0);
    step(10, 1);
    chk("R6 single xoff done", remote_stopped_o, 1);
    step(2, 0);
    step(2, 1);
    chk("R6 single xon done", remote_stopped_o, 0);

    // R9 stall with count swing
    dual_char_i = 1;
    do_reset();
    step(12, 0);
    for (int i = 0; i < 5; i++) step(i, 0);
    chk("R9 held", ins_valid_o, 1);
    step(0, 1);
    step(0, 0);

    // random mix
    xon1_i = 8'h5a; xon2_i = 8'ha5; xoff1_i = 8'h3c; xoff2_i = 8'hc3;
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int lim;
      if ($urandom_range(0, 99) == 0) begin
        deep_mode_i = 1'($urandom);
        trig_sel_i  = 2'($urandom);
        dual_char_i = 1'($urandom);
      end
      lim = deep_mode_i ? 64 : 16;
      step($urandom_range(0, lim), 1'($urandom_range(0, 2) != 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule